// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small single-cycle RISC core. It combines two 8-bit operands and an operation code into an 8-bit result, a write-back enable for the register file and the next value of an 8-bit status word. The operands may come from a register or an immediate, and the core's decoder selects which. The status word itself is kept in a register inside the block and is offered to the core for branch conditions.

Each operation updates its own set of flags and leaves the other flags as they were. Compares set flags and write back nothing. Complement forces carry high. Increment and decrement preserve carry. The borrow-chained forms fold the previous zero flag into the new one, so a multi-byte compare or subtract gives a zero flag that is true only when every byte was zero. A set-flag or clear-flag operation touches exactly one status bit and produces no result.

The status register loads the computed next value on a clock edge when `op_valid` is high. It holds its value when `op_valid` is low. There is no state machine: the status register is the block's only storage.

Top module: `alu8_core`

## Requirements
- R1: After reset `status_q` is 0x00. On a rising clock edge with `op_valid` high it loads `status_nxt`, and with `op_valid` low it keeps its value. Status bit positions from 7 to 0 are: interrupt-enable, bit-copy T, half-carry H, sign S, overflow V, negative N, zero Z, carry C.
- R2: Add (op 0) and add-with-carry (op 1, which also adds C) write a+b(+C). They set C to the carry out of bit 7 and H to the carry out of bit 3. They set V when a and b have the same sign and the result's sign differs. N, Z and S are updated as well.
- R3: Subtract (op 2) and subtract-with-carry (op 3, which also subtracts C) write a-b(-C). They set C to the borrow out of bit 7, H to the borrow out of bit 3 and V to signed overflow, and update N and S. For op 2, Z is set when the result is zero. For op 3, Z keeps its old value when the result is zero and is cleared otherwise.
- R4: Compare (op 4) and compare-with-carry (op 5) update the flags exactly as ops 2 and 3 do, and keep `wr_en` low.
- R5: AND (op 6), OR (op 7) and XOR (op 8) of a and b update Z and N, clear V, set S to N, and leave C, H, T and the interrupt bit unchanged.
- R6: Complement (op 9) writes 0xFF-a. It sets C to 1, clears V, updates Z, N and S, and leaves H unchanged.
- R7: Negate (op 10) writes 0x00-a. It sets C when a is nonzero, sets V when a is 0x80, sets H to the bit-3 borrow of 0-a, and updates Z, N and S.
- R8: Increment (op 11) and decrement (op 12) write a+1 and a-1. Increment sets V when a is 0x7F, and decrement sets V when a is 0x80. Both update Z, N and S and leave C and H unchanged.
- R9: Shift left (op 13) and shift right (op 14) bring a zero into the vacated bit. Rotate left (op 15) and rotate right (op 16) bring the old C into the vacated bit. Arithmetic shift right (op 17) keeps bit 7. In all five, C takes the bit shifted out, V is N XOR C, and Z, N and S are updated while H is left unchanged.
- R10: Swap (op 18) writes a with its nibbles exchanged. Load-ones (op 19) writes 0xFF. Neither changes any status bit.
- R11: Flag set (op 20) and flag clear (op 21) write 1 or 0 to the status bit numbered by `flag_idx`, change no other bit and keep `wr_en` low.
- R12: Whenever an operation updates N or V, the new S equals new N XOR new V.
- R13: Op codes 22 to 31 keep `wr_en` low and leave the status word unchanged. For every write-back op, `wr_en` equals `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand (destination register value) |
| opnd_b | input | 8 | Second operand (register or immediate) |
| flag_idx | input | 3 | Status bit selected by flag set/clear |
| result | output | 8 | Computed result |
| wr_en | output | 1 | Result is to be written back |
| status_q | output | 8 | Current status register |
| status_nxt | output | 8 | Status value loaded on the next valid edge |

## Verification
The bench runs a cycle-accurate reference model built on integer arithmetic and compares it with the block on every operation. Directed cases target the boundaries that separate one flag rule from another: 0x7F+1 and 0x80-1 for overflow, 0xFF+1 for carry with a zero result, and a nibble carry without a byte carry for H. A two-byte borrow chain shows whether Z is kept or cleared across bytes, and a compare of equal values tells a compare apart from a subtract only through `wr_en`. A long pseudo-random run over all 32 op codes, random carry-in and occasional idle cycles then checks that flags are kept or changed per operation, including the unused codes.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    localparam int OP_W   = 5;
    localparam int STAT_W = 8;

    // status bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_SER  = 5'd19,
        OP_FSET = 5'd20,
        OP_FCLR = 5'd21
    } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith #(
    parameter int DATA_W = 8,
    parameter int HALF_W = 4
) (
    input  logic              sub_mode,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;
    logic [HALF_W:0] nib;

    always_comb begin
        if (sub_mode) begin
            wide = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, x[HALF_W-1:0]} - {1'b0, y[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin};
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, x[HALF_W-1:0]} + {1'b0, y[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        end
        sum   = wide[DATA_W-1:0];
        c_out = wide[DATA_W];
        h_out = nib[HALF_W];
        if (sub_mode)
            v_out = (x[MSB] ^ y[MSB]) & (x[MSB] ^ wide[MSB]);
        else
            v_out = ~(x[MSB] ^ y[MSB]) & (x[MSB] ^ wide[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/1ps
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;

    always_comb begin
        res   = '0;
        c_out = cin;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  begin res = ~a;                  c_out = 1'b1;  end
            OP_LSL:  begin res = {a[MSB-1:0], 1'b0};  c_out = a[MSB]; end
            OP_LSR:  begin res = {1'b0, a[MSB:1]};    c_out = a[0];   end
            OP_ROL:  begin res = {a[MSB-1:0], cin};   c_out = a[MSB]; end
            OP_ROR:  begin res = {cin, a[MSB:1]};     c_out = a[0];   end
            OP_ASR:  begin res = {a[MSB], a[MSB:1]};  c_out = a[0];   end
            OP_SWAP: res = {a[HALF-1:0], a[MSB:HALF]};
            OP_SER:  res = '1;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        flag_idx,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] status_nxt
);
    localparam int MSB = DATA_W - 1;

    typedef enum logic [2:0] {
        CL_NONE, CL_ARITH, CL_LOGIC, CL_SHIFT, CL_PLAIN, CL_FLAG
    } op_class_e;

    alu_op_e     op;
    op_class_e   cls;
    logic        a_sub, a_cin, a_c, a_h, a_v, b_c;
    logic [DATA_W-1:0] a_x, a_y, a_sum, b_res;
    logic        writes;

    assign op = alu_op_e'(op_sel);

    // operand steering for the shared adder/subtractor
    always_comb begin
        a_sub = 1'b0;
        a_cin = 1'b0;
        a_x   = opnd_a;
        a_y   = opnd_b;
        cls   = CL_NONE;
        unique case (op)
            OP_ADD:  cls = CL_ARITH;
            OP_ADC:  begin cls = CL_ARITH; a_cin = status_q[FL_C]; end
            OP_SUB, OP_CP:   begin cls = CL_ARITH; a_sub = 1'b1; end
            OP_SBC, OP_CPC:  begin cls = CL_ARITH; a_sub = 1'b1; a_cin = status_q[FL_C]; end
            OP_NEG:  begin cls = CL_ARITH; a_sub = 1'b1; a_x = '0; a_y = opnd_a; end
            OP_INC:  begin cls = CL_ARITH; a_y = {{(DATA_W-1){1'b0}}, 1'b1}; end
            OP_DEC:  begin cls = CL_ARITH; a_sub = 1'b1; a_y = {{(DATA_W-1){1'b0}}, 1'b1}; end
            OP_AND, OP_OR, OP_XOR, OP_COM:  cls = CL_LOGIC;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: cls = CL_SHIFT;
            OP_SWAP, OP_SER: cls = CL_PLAIN;
            OP_FSET, OP_FCLR: cls = CL_FLAG;
            default: cls = CL_NONE;
        endcase
    end

    alu8_arith #(.DATA_W(DATA_W), .HALF_W(4)) u_arith (
        .sub_mode (a_sub),
        .x        (a_x),
        .y        (a_y),
        .cin      (a_cin),
        .sum      (a_sum),
        .c_out    (a_c),
        .h_out    (a_h),
        .v_out    (a_v)
    );

    alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .cin   (status_q[FL_C]),
        .res   (b_res),
        .c_out (b_c)
    );

    // result, write-back and next status
    always_comb begin
        logic n_f, v_f, z_f;
        status_nxt = status_q;
        result     = '0;
        writes     = 1'b0;
        n_f = 1'b0;
        v_f = 1'b0;
        z_f = 1'b0;
        unique case (cls)
            CL_ARITH: begin
                result = a_sum;
                writes = !(op == OP_CP || op == OP_CPC);
                n_f = a_sum[MSB];
                v_f = a_v;
                z_f = (a_sum == '0);
                if (op == OP_SBC || op == OP_CPC)
                    z_f = z_f & status_q[FL_Z];
                status_nxt[FL_N] = n_f;
                status_nxt[FL_V] = v_f;
                status_nxt[FL_Z] = z_f;
                status_nxt[FL_S] = n_f ^ v_f;
                if (op != OP_INC && op != OP_DEC) begin
                    status_nxt[FL_C] = a_c;
                    status_nxt[FL_H] = a_h;
                end
            end
            CL_LOGIC: begin
                result = b_res;
                writes = 1'b1;
                n_f = b_res[MSB];
                status_nxt[FL_N] = n_f;
                status_nxt[FL_V] = 1'b0;
                status_nxt[FL_Z] = (b_res == '0);
                status_nxt[FL_S] = n_f;
                status_nxt[FL_C] = b_c;
            end
            CL_SHIFT: begin
                result = b_res;
                writes = 1'b1;
                n_f = b_res[MSB];
                v_f = n_f ^ b_c;
                status_nxt[FL_N] = n_f;
                status_nxt[FL_V] = v_f;
                status_nxt[FL_Z] = (b_res == '0);
                status_nxt[FL_S] = n_f ^ v_f;
                status_nxt[FL_C] = b_c;
            end
            CL_PLAIN: begin
                result = b_res;
                writes = 1'b1;
            end
            CL_FLAG: begin
                status_nxt[flag_idx] = (op == OP_FSET);
            end
            default: begin
                writes = 1'b0;
            end
        endcase
    end

    assign wr_en = op_valid & writes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= '0;
        else if (op_valid)
            status_q <= status_nxt;
    end

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status_q));

    a_r4_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CP || op_sel == OP_CPC) |-> !wr_en);

    a_r5_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
        |=> !status_q[FL_V] && (status_q[FL_S] == status_q[FL_N]));

    a_r8_incdec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_INC || op_sel == OP_DEC))
        |=> status_q[FL_C] == $past(status_q[FL_C]));

    a_r10_swap_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_SWAP || op_sel == OP_SER)) |=> $stable(status_q));

    a_r6_com_sets_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_COM) |=> status_q[FL_C]);

    a_r13_unused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_FCLR) |-> !wr_en && (status_nxt == status_q));

    a_r12_sign_link: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= OP_ASR) |=> status_q[FL_S] == (status_q[FL_N] ^ status_q[FL_V]));
endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [2:0] flag_idx = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [7:0] status_q;
    logic [7:0] status_nxt;

    int n_chk = 0;
    int n_bad = 0;
    int model_st = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_idx(flag_idx),
        .result(result), .wr_en(wr_en), .status_q(status_q), .status_nxt(status_nxt)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        if (op <= 1) return "R2";
        if (op <= 3) return "R3";
        if (op <= 5) return "R4";
        if (op <= 8) return "R5";
        if (op == 9) return "R6";
        if (op == 10) return "R7";
        if (op <= 12) return "R8";
        if (op <= 17) return "R9";
        if (op <= 19) return "R10";
        if (op <= 21) return "R11";
        return "R13";
    endfunction

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int put(input int st, input int pos, input int val);
        return (st & ~(1 << pos)) | ((val & 1) << pos);
    endfunction

    // R12: S follows N and V whenever they are written
    function automatic int znvs(input int st, input int r, input int v);
        int s;
        s = put(st, 1, (r == 0) ? 1 : 0);
        s = put(s, 2, r >> 7);
        s = put(s, 3, v);
        s = put(s, 4, (r >> 7) ^ v);
        return s;
    endfunction

    task automatic model(input int op, input int a, input int b, input int idx,
                         input int st, output int r, output int wb, output int ns);
        int c, z, full, sv, ci, co, zz;
        c = st & 1;
        z = (st >> 1) & 1;
        r = 0; wb = 1; ns = st;
        case (op)
            0, 1: begin
                ci = (op == 1) ? c : 0;
                full = a + b + ci; r = full & 255;
                sv = sx(a) + sx(b) + ci;
                ns = znvs(st, r, (sv > 127 || sv < -128) ? 1 : 0);
                ns = put(ns, 0, full > 255 ? 1 : 0);
                ns = put(ns, 5, ((a & 15) + (b & 15) + ci) > 15 ? 1 : 0);
            end
            2, 3, 4, 5: begin
                ci = (op == 3 || op == 5) ? c : 0;
                full = a - b - ci; r = full & 255;
                sv = sx(a) - sx(b) - ci;
                ns = znvs(st, r, (sv > 127 || sv < -128) ? 1 : 0);
                ns = put(ns, 0, full < 0 ? 1 : 0);
                ns = put(ns, 5, ((a & 15) - (b & 15) - ci) < 0 ? 1 : 0);
                if (op == 3 || op == 5) begin
                    zz = (r == 0 && z == 1) ? 1 : 0;
                    ns = put(ns, 1, zz);
                end
                if (op >= 4) wb = 0;
            end
            6: begin r = a & b; ns = znvs(st, r, 0); end
            7: begin r = a | b; ns = znvs(st, r, 0); end
            8: begin r = a ^ b; ns = znvs(st, r, 0); end
            9: begin r = 255 - a; ns = put(znvs(st, r, 0), 0, 1); end
            10: begin
                r = (256 - a) & 255;
                ns = znvs(st, r, (a == 128) ? 1 : 0);
                ns = put(ns, 0, (a != 0) ? 1 : 0);
                ns = put(ns, 5, (a & 15) != 0 ? 1 : 0);
            end
            11: begin r = (a + 1) & 255; ns = znvs(st, r, (a == 127) ? 1 : 0); end
            12: begin r = (a + 255) & 255; ns = znvs(st, r, (a == 128) ? 1 : 0); end
            13, 14, 15, 16, 17: begin
                case (op)
                    13: begin r = (a * 2) & 255; co = a >> 7; end
                    14: begin r = a / 2; co = a & 1; end
                    15: begin r = ((a * 2) & 255) + c; co = a >> 7; end
                    16: begin r = a / 2 + c * 128; co = a & 1; end
                    default: begin r = a / 2 + (a & 128); co = a & 1; end
                endcase
                ns = znvs(st, r, (r >> 7) ^ co);
                ns = put(ns, 0, co);
            end
            18: r = ((a % 16) * 16) + (a / 16);
            19: r = 255;
            20: begin wb = 0; ns = put(st, idx, 1); end
            21: begin wb = 0; ns = put(st, idx, 0); end
            default: wb = 0;
        endcase
    endtask

    task automatic run_op(input int op, input int a, input int b, input int idx, input bit v);
        int r, wb, ns;
        string t;
        @(negedge clk);
        op_sel = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        flag_idx = idx[2:0]; op_valid = v;
        model(op, a, b, idx, model_st, r, wb, ns);
        t = tag_of(op);
        #1;
        if (wb == 1) chk(result == r[7:0], t, "result", result, r);
        chk(wr_en == (v && wb == 1), t, "wr_en", wr_en, (v && wb == 1));
        chk(status_nxt == ns[7:0], t, "status_nxt", status_nxt, ns);
        if (v) model_st = ns;
        @(posedge clk); #1;
        chk(status_q == model_st[7:0], v ? t : "R1", "status_q", status_q, model_st);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(status_q == 8'h00, "R1", "reset status", status_q, 0);
        rst_n = 1'b1;
        // R2 boundaries
        run_op(0, 8'h7F, 8'h01, 0, 1);
        run_op(0, 8'hFF, 8'h01, 0, 1);
        run_op(1, 8'h0F, 8'h00, 0, 1);
        run_op(0, 8'h08, 8'h08, 0, 1);
        // R3 two-byte borrow chain, zero chaining
        run_op(2, 8'h00, 8'h00, 0, 1);
        run_op(3, 8'h00, 8'h00, 0, 1);
        run_op(2, 8'h00, 8'h01, 0, 1);
        run_op(3, 8'h01, 8'h00, 0, 1);
        run_op(2, 8'h80, 8'h01, 0, 1);
        // R4 compare of equal values
        run_op(4, 8'h55, 8'h55, 0, 1);
        run_op(5, 8'h10, 8'h20, 0, 1);
        // R5..R11
        run_op(6, 8'hF0, 8'h0F, 0, 1);
        run_op(8, 8'hAA, 8'h55, 0, 1);
        run_op(9, 8'h00, 8'h00, 0, 1);
        run_op(10, 8'h80, 8'h00, 0, 1);
        run_op(10, 8'h00, 8'h00, 0, 1);
        run_op(11, 8'h7F, 8'h00, 0, 1);
        run_op(12, 8'h80, 8'h00, 0, 1);
        run_op(15, 8'h80, 8'h00, 0, 1);
        run_op(16, 8'h01, 8'h00, 0, 1);
        run_op(17, 8'h81, 8'h00, 0, 1);
        run_op(18, 8'h3C, 8'h00, 0, 1);
        run_op(19, 8'h00, 8'h00, 0, 1);
        run_op(20, 0, 0, 7, 1);
        run_op(20, 0, 0, 6, 1);
        run_op(21, 0, 0, 7, 1);
        // R1 idle and R13 unused code
        run_op(0, 8'hFF, 8'hFF, 0, 0);
        run_op(27, 8'h12, 8'h34, 0, 1);
        for (int i = 0; i < 3000; i++) begin
            run_op($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
                   $urandom_range(0, 7), ($urandom_range(0, 7) != 0));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule